// File: doc/BRIEF.md
# Byte-Wide Programmable Memory with Control-Pin Mode Decode

This block is a synthesizable model of a byte-wide memory that leaves erase with every bit set and can afterwards only have bits cleared by programming. Four control inputs choose the operating mode: an active-low chip select, an active-low read strobe, an active-low program strobe and a flag that says whether the program supply is present. A fifth flag, the identifier enable, takes the place of the raised-voltage pin that brings out the two identifier bytes. The decoded mode sets whether the data port drives, what it returns, and whether the stored byte at the current address is altered.

Every pin is sampled on the rising clock edge. The mode, the output data and the drive flag are registered, so they show the pins of the edge just before. A synchronous reset stands in for erase: it sets every stored byte to all ones and puts the outputs in standby. A system reads the block like a normal memory. A programmer applies an address and a byte, pulses the program strobe, and then checks the byte in verify mode.

Top module: `prom_mode_ctrl`

## Requirements
- R1: The pins decode to exactly one mode, shown on `mode_o` with this encoding: read=0, output-off=1, standby=2, program=3, verify=4, inhibit=5, identifier=6. Chip select high gives standby when the supply flag is low and inhibit when it is high. With chip select low and the supply flag high: program strobe low with read strobe high gives program; program strobe high with read strobe low gives verify; any other strobe pair gives inhibit. With chip select low and the supply flag low: read strobe low gives identifier if `id_en` is high and read otherwise; read strobe high gives output-off.
- R2: Pins are sampled on a rising edge, and `mode_o`, `dq_out` and `dq_oe` take the matching values at that same edge, one register stage after the inputs.
- R3: Reset (`rst_n` low at a rising edge) sets every stored byte to 8'hFF, `mode_o` to standby, `dq_oe` to 0 and `dq_out` to 8'hFF.
- R4: Each rising edge in program mode replaces the addressed byte with its old value ANDed with `dq_in`. A bit that has been cleared stays cleared until the next reset.
- R5: The store is left unchanged in every mode other than program. This includes a low program strobe seen in inhibit, standby or read mode.
- R6: `dq_oe` is 1 only in read, verify and identifier modes. Whenever `dq_oe` is 0, `dq_out` is 8'hFF.
- R7: Read and verify return the byte held at `addr` as it stood before that edge.
- R8: Identifier mode returns parameter `MFG_ID` (default 8'h97) when `addr` is 0, `DEV_ID` (default 8'h32) when `addr` is 1, and 8'hFF when any address bit above bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; acts as erase |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Program data |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read strobe |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_on | input | 1 | Program supply present |
| id_en | input | 1 | Identifier access request |
| dq_out | output | 8 | Registered output data |
| dq_oe | output | 1 | Output drive enable |
| mode_o | output | 3 | Registered decoded mode |

## Verification
The bench programs one byte twice with different patterns and then once more with all ones. A design that wrote `dq_in` straight into the store would show the later pattern or 8'hFF where 8'h50 is expected. It holds the program strobe low while chip select is high, while both strobes are low, and while the supply flag is low, then reads the byte back. A design that wrote in any of these modes would return 8'h00 in place of 8'hFF. It asks for the identifier bytes with a clean address and with upper address bits set, which catches a decode that looks only at bit 0. It also raises the identifier flag while the supply flag is high, which catches a design that gives the identifier priority over verify. A final reset followed by a read catches an erase that fails to restore all ones.

// File: rtl/prom_pkg.sv
package prom_pkg;

    typedef enum logic [2:0] {
        MD_READ    = 3'd0,
        MD_ODIS    = 3'd1,
        MD_STBY    = 3'd2,
        MD_PROG    = 3'd3,
        MD_VERIFY  = 3'd4,
        MD_INHIBIT = 3'd5,
        MD_ID      = 3'd6
    } prom_mode_e;

    // Modes in which the data port is driven
    function automatic logic mode_drives(input prom_mode_e m);
        return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_ID);
    endfunction

endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
    import prom_pkg::*;
(
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       pgm_n,
    input  logic       vpp_on,
    input  logic       id_en,
    output prom_mode_e mode,
    output logic       wr_en
);

    always_comb begin
        if (ce_n) begin
            // deselected: supply present blocks programming, else standby
            mode = vpp_on ? MD_INHIBIT : MD_STBY;
        end else if (vpp_on) begin
            // programming bench: strobes must be complementary
            if (!pgm_n && oe_n) begin
                mode = MD_PROG;
            end else if (pgm_n && !oe_n) begin
                mode = MD_VERIFY;
            end else begin
                mode = MD_INHIBIT;
            end
        end else if (!oe_n) begin
            mode = id_en ? MD_ID : MD_READ;
        end else begin
            mode = MD_ODIS;
        end
        wr_en = (mode == MD_PROG);
    end

endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    // Next-state: programming can only pull bits toward zero
    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[addr] = mem_q[addr] & wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    // Value before the current edge's update
    assign rd_data = mem_q[addr];

endmodule

// File: rtl/prom_out_stage.sv
module prom_out_stage
    import prom_pkg::*;
#(
    parameter int          ADDR_W = 10,
    parameter int          DATA_W = 8,
    parameter logic [7:0]  MFG_ID = 8'h97,
    parameter logic [7:0]  DEV_ID = 8'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  prom_mode_e        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout,
    output logic              oe,
    output logic [2:0]        mode_out
);

    localparam logic [DATA_W-1:0] IDLE_VAL = '1;

    typedef struct packed {
        prom_mode_e        mode;
        logic              oe;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t out_d, out_q;
    logic upper_set;
    logic [DATA_W-1:0] id_byte;

    assign upper_set = |addr[ADDR_W-1:1];

    always_comb begin
        if (upper_set) begin
            id_byte = IDLE_VAL;
        end else if (addr[0]) begin
            id_byte = DATA_W'(DEV_ID);
        end else begin
            id_byte = DATA_W'(MFG_ID);
        end
    end

    always_comb begin
        out_d.mode = mode;
        out_d.oe   = mode_drives(mode);
        unique case (mode)
            MD_READ, MD_VERIFY: out_d.data = rd_data;
            MD_ID:              out_d.data = id_byte;
            default:            out_d.data = IDLE_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.mode <= MD_STBY;
            out_q.oe   <= 1'b0;
            out_q.data <= IDLE_VAL;
        end else begin
            out_q <= out_d;
        end
    end

    assign dout     = out_q.data;
    assign oe       = out_q.oe;
    assign mode_out = out_q.mode;

endmodule

// File: rtl/prom_mode_ctrl.sv
module prom_mode_ctrl
    import prom_pkg::*;
#(
    parameter int         ADDR_W = 10,
    parameter logic [7:0] MFG_ID = 8'h97,
    parameter logic [7:0] DEV_ID = 8'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_on,
    input  logic              id_en,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic [2:0]        mode_o
);

    localparam int DATA_W = 8;

    prom_mode_e        cur_mode;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;

    prom_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_on (vpp_on),
        .id_en  (id_en),
        .mode   (cur_mode),
        .wr_en  (wr_en)
    );

    prom_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (dq_in),
        .rd_data (rd_data)
    );

    prom_out_stage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MFG_ID (MFG_ID),
        .DEV_ID (DEV_ID)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cur_mode),
        .addr     (addr),
        .rd_data  (rd_data),
        .dout     (dq_out),
        .oe       (dq_oe),
        .mode_out (mode_o)
    );

endmodule

// File: rtl/prom_mode_chk.sv
module prom_mode_chk #(
    parameter logic [7:0] MFG_ID = 8'h97,
    parameter logic [7:0] DEV_ID = 8'h32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       pgm_n,
    input logic       vpp_on,
    input logic [7:0] dq_out,
    input logic       dq_oe,
    input logic [2:0] mode_o
);

    AST_DRIVE_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe == (mode_o == 3'd0 || mode_o == 3'd4 || mode_o == 3'd6)); // R6

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> dq_out == 8'hFF); // R6

    AST_DESELECT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!dq_oe && (mode_o == 3'd2 || mode_o == 3'd5))); // R1

    AST_PROG_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && vpp_on && !pgm_n && oe_n) |=> (mode_o == 3'd3 && !dq_oe)); // R1

    AST_ID_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd6 |-> (dq_out == MFG_ID || dq_out == DEV_ID || dq_out == 8'hFF)); // R8

    AST_MODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 3'd7); // R1

endmodule

bind prom_mode_ctrl prom_mode_chk #(
    .MFG_ID (MFG_ID),
    .DEV_ID (DEV_ID)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .pgm_n  (pgm_n),
    .vpp_on (vpp_on),
    .dq_out (dq_out),
    .dq_oe  (dq_oe),
    .mode_o (mode_o)
);

// File: tb/sim_prom_mode_ctrl.sv
`timescale 1ns/1ps
module sim_prom_mode_ctrl;

    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        dq_in = 8'hFF;
    logic              ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
    logic              vpp_on = 1'b0, id_en = 1'b0;
    logic [7:0]        dq_out;
    logic              dq_oe;
    logic [2:0]        mode_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        string      tag;
        logic [2:0] mode;
        logic       oe;
        logic [7:0] data;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    prom_mode_ctrl #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .dq_in(dq_in),
        .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .vpp_on(vpp_on), .id_en(id_en),
        .dq_out(dq_out), .dq_oe(dq_oe), .mode_o(mode_o)
    );

    task automatic compare(input string tag, input logic [2:0] m, input logic o, input logic [7:0] d);
        checks++;
        if (mode_o !== m || dq_oe !== o || dq_out !== d) begin
            errors++;
            $display("FAIL %s: got mode=%0d oe=%0b data=%02h, expected mode=%0d oe=%0b data=%02h",
                     tag, mode_o, dq_oe, dq_out, m, o, d);
        end
    endtask

    // Monitor: results appear at the edge that sampled the pins
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            compare(e.tag, e.mode, e.oe, e.data);
        end
    end

    // Driver: apply pins at a falling edge, push the expected result
    task automatic step(input logic c, input logic o, input logic p, input logic v, input logic s,
                        input logic [ADDR_W-1:0] a, input logic [7:0] din,
                        input logic [2:0] em, input logic eo, input logic [7:0] ed, input string tag);
        exp_t e;
        @(negedge clk);
        ce_n = c; oe_n = o; pgm_n = p; vpp_on = v; id_en = s; addr = a; dq_in = din;
        e.tag = tag; e.mode = em; e.oe = eo; e.data = ed;
        sb_q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1; vpp_on = 1'b0; id_en = 1'b0;
        repeat (2) @(negedge clk);
        compare("R3 reset state", 3'd2, 1'b0, 8'hFF);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        //    ce oe pg vp id addr    din    mode oe data
        step(0, 0, 1, 0, 0, 10'd5,  8'hFF, 3'd0, 1, 8'hFF, "R3 R7 erased byte reads FF");
        step(0, 1, 1, 0, 0, 10'd5,  8'hFF, 3'd1, 0, 8'hFF, "R1 R6 output off");
        step(1, 0, 1, 0, 0, 10'd5,  8'hFF, 3'd2, 0, 8'hFF, "R1 standby");
        step(0, 1, 0, 1, 0, 10'd5,  8'h5A, 3'd3, 0, 8'hFF, "R1 program mode");
        step(0, 0, 1, 1, 0, 10'd5,  8'hFF, 3'd4, 1, 8'h5A, "R2 R4 verify first program");
        step(0, 1, 0, 1, 0, 10'd5,  8'hF0, 3'd3, 0, 8'hFF, "R4 second program");
        step(0, 0, 1, 1, 0, 10'd5,  8'hFF, 3'd4, 1, 8'h50, "R4 AND of two patterns");
        step(0, 1, 0, 1, 0, 10'd5,  8'hFF, 3'd3, 0, 8'hFF, "R4 program all ones");
        step(0, 0, 1, 0, 0, 10'd5,  8'hFF, 3'd0, 1, 8'h50, "R4 cleared bits stay cleared");
        step(1, 1, 0, 1, 0, 10'd6,  8'h00, 3'd5, 0, 8'hFF, "R1 inhibit by chip select high");
        step(0, 1, 1, 1, 0, 10'd6,  8'h00, 3'd5, 0, 8'hFF, "R1 inhibit both strobes high");
        step(0, 0, 0, 1, 0, 10'd6,  8'h00, 3'd5, 0, 8'hFF, "R1 inhibit both strobes low");
        step(0, 0, 0, 0, 0, 10'd6,  8'h00, 3'd0, 1, 8'hFF, "R5 strobe low without supply");
        step(0, 0, 1, 0, 0, 10'd6,  8'h00, 3'd0, 1, 8'hFF, "R5 byte untouched after inhibit");
        step(0, 0, 1, 0, 1, 10'd0,  8'hFF, 3'd6, 1, 8'h97, "R8 manufacturer byte");
        step(0, 0, 1, 0, 1, 10'd1,  8'hFF, 3'd6, 1, 8'h32, "R8 device byte");
        step(0, 0, 1, 0, 1, 10'd2,  8'hFF, 3'd6, 1, 8'hFF, "R8 upper bit set");
        step(0, 0, 1, 0, 1, 10'h201, 8'hFF, 3'd6, 1, 8'hFF, "R8 top bit set with bit0");
        step(0, 0, 1, 1, 1, 10'd5,  8'hFF, 3'd4, 1, 8'h50, "R1 verify wins over identifier");
        step(0, 1, 1, 0, 1, 10'd0,  8'hFF, 3'd1, 0, 8'hFF, "R1 R6 identifier with read strobe high");
        step(0, 1, 0, 1, 0, 10'd1023, 8'h0F, 3'd3, 0, 8'hFF, "R4 program last address");
        step(0, 0, 1, 1, 0, 10'd1023, 8'hFF, 3'd4, 1, 8'h0F, "R7 verify last address");
        step(0, 0, 1, 0, 0, 10'd0,  8'hFF, 3'd0, 1, 8'hFF, "R5 R7 neighbour unaffected");
        repeat (3) @(negedge clk);
        do_reset();
        step(0, 0, 1, 0, 0, 10'd5,  8'hFF, 3'd0, 1, 8'hFF, "R3 erase restores ones");
        step(0, 0, 1, 0, 0, 10'd1023, 8'hFF, 3'd0, 1, 8'hFF, "R3 erase last address");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule